// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block sits beside the data path of a NAND flash controller. While a page moves across that path, it builds a Hamming code over each 256-byte chunk of the page. The code corrects any one flipped bit in a chunk and detects two. A 512-byte page is two independent chunks and yields six code bytes. Each chunk has its own accumulator. An internal byte counter steps to the next accumulator after 256 accepted bytes.

A two-bit mode input controls the block:

- Clear wipes every accumulator and the counters.
- Accumulate folds each strobed byte into the current chunk.
- Read-out presents the finished code bytes one at a time.
- Idle leaves all state alone.

To arm the block, software steps the mode through clear, idle and then accumulate. To collect the code, it goes to idle, then to read-out, and pulses the read strobe once per code byte. The bytes of each chunk come out in a permuted order. It then returns to idle.

Top module: `nand_hecc_gen`

## Requirements
- R1: After the synchronous reset, every code byte read out equals 8'hFF. This is the code of an untouched or all-zero chunk.
- R2: One cycle of mode 2'b11 returns every accumulator to the empty state and the byte and chunk counters to zero. A read-out that follows then gives 8'hFF for every byte.
- R3: In mode 2'b01, every cycle with byte_valid high folds byte_data into the line parity of the current chunk, using the parity of the whole byte. The byte's address inside the chunk is a. For each address bit k (0..7), stored byte k/4 holds at bit 2*(k%4)+1 the parity over bytes with a[k]=1, and at bit 2*(k%4) the parity over bytes with a[k]=0.
- R4: Stored byte 2 holds the column parities in bits 7:2, and its bits 1:0 are always 1. From bit 2 upward, the six column parities cover these data bits:
  - bits 0,2,4,6
  - bits 1,3,5,7
  - bits 0,1,4,5
  - bits 2,3,6,7
  - bits 0..3
  - bits 4..7
- R5: Every parity bit is stored inverted: a zero parity reads as 1.
- R6: The first 256 accepted bytes go to chunk 0 and the next 256 go to chunk 1. Bytes strobed after 512 have been accepted change nothing.
- R7: In mode 2'b10, ecc_byte shows the current code byte, and each rd_strobe cycle advances to the next one. For each chunk in turn, starting with chunk 0, the order is stored byte 1, then byte 0, then byte 2. After the sixth byte the sequence wraps to the first.
- R8: Whenever the mode is anything but 2'b10, the read-out position returns to the start.
- R9: In modes 2'b00 and 2'b10, byte_valid has no effect on the code.
- R10: ecc_byte is 8'h00 whenever the mode is not 2'b10.
- R11: Take two chunks that differ in a single data bit. XOR their codes. In each of the 11 even/odd parity pairs, exactly one bit of the result is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 idle, 01 accumulate, 10 read-out, 11 clear |
| byte_valid | input | 1 | A data byte crosses the flash data path this cycle |
| byte_data | input | 8 | The byte on the data path |
| rd_strobe | input | 1 | Read of the data register; advances the read-out position |
| ecc_byte | output | 8 | Current code byte in read-out mode, zero otherwise |

## Verification
The code is computed under five kinds of input:

- A mixed arithmetic pattern over a full page, which exercises every line and column pair at once.
- A page of all-ones bytes, whose per-byte parity is even and which must give the same code as an empty chunk.
- A single set bit at one address, which separates the even and odd halves of each line pair and shows that an address bit maps to the right pair.
- A second chunk that differs from the first by one flipped bit, whose code difference must hit exactly one bit of every pair.
- Strobes sent while idle, while reading out, and after the page is full, which must leave the code exactly as the counted bytes alone would produce.

// File: rtl/nhecc_pkg.sv
package nhecc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ACC   = 2'b01,
        MODE_READ  = 2'b10,
        MODE_CLEAR = 2'b11
    } ecc_mode_e;

    localparam int COL_W = 6;

    // Column parity of one byte: pairs over alternating bits, bit pairs, nibbles
    function automatic logic [COL_W-1:0] col_parity(input logic [7:0] d);
        logic [COL_W-1:0] c;
        c[0] = ^(d & 8'h55);
        c[1] = ^(d & 8'hAA);
        c[2] = ^(d & 8'h33);
        c[3] = ^(d & 8'hCC);
        c[4] = ^(d & 8'h0F);
        c[5] = ^(d & 8'hF0);
        return c;
    endfunction

    // Read slot to stored byte index: 0->1, 1->0, others unchanged
    function automatic int unsigned slot_to_index(input int unsigned slot);
        if (slot == 0) return 1;
        if (slot == 1) return 0;
        return slot;
    endfunction

endpackage

// File: rtl/nhecc_seq.sv
module nhecc_seq
    import nhecc_pkg::*;
#(
    parameter int AW         = 8,
    parameter int NUM_CHUNKS = 2,
    localparam int CW        = $clog2(NUM_CHUNKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          byte_valid,
    output logic [AW-1:0] byte_addr,
    output logic [CW-1:0] chunk_sel,
    output logic          acc_en,
    output logic          clear
);
    logic room;
    logic last_byte;

    assign room      = (chunk_sel < CW'(NUM_CHUNKS));
    assign last_byte = (byte_addr == {AW{1'b1}});
    assign clear     = (mode == MODE_CLEAR);
    assign acc_en    = (mode == MODE_ACC) && byte_valid && room;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            byte_addr <= '0;
            chunk_sel <= '0;
        end else if (acc_en) begin
            byte_addr <= byte_addr + 1'b1;
            if (last_byte) begin
                chunk_sel <= chunk_sel + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nhecc_acc.sv
module nhecc_acc
    import nhecc_pkg::*;
#(
    parameter int AW     = 8,
    localparam int LINE_W = 2 * AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        data,
    output logic [LINE_W-1:0] line_par,
    output logic [COL_W-1:0]  col_par
);
    logic              byte_par;
    logic [LINE_W-1:0] line_nxt;
    logic [COL_W-1:0]  col_nxt;

    assign byte_par = ^data;

    always_comb begin
        line_nxt = line_par;
        for (int k = 0; k < AW; k++) begin
            if (addr[k]) begin
                line_nxt[2*k+1] = line_par[2*k+1] ^ byte_par;
            end else begin
                line_nxt[2*k]   = line_par[2*k] ^ byte_par;
            end
        end
        col_nxt = col_par ^ col_parity(data);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            line_par <= '0;
            col_par  <= '0;
        end else if (en) begin
            line_par <= line_nxt;
            col_par  <= col_nxt;
        end
    end
endmodule

// File: rtl/nhecc_rd.sv
module nhecc_rd
    import nhecc_pkg::*;
#(
    parameter int NUM_CHUNKS = 2,
    parameter int CODE_BYTES = 3,
    localparam int CODE_W    = CODE_BYTES * 8,
    localparam int CPW       = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
    localparam int SPW       = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [1:0]                         mode,
    input  logic                               rd_strobe,
    input  logic [NUM_CHUNKS-1:0][CODE_W-1:0]  codes,
    output logic [7:0]                         ecc_byte
);
    logic [CPW-1:0] chunk_ptr;
    logic [SPW-1:0] slot_ptr;
    logic           reading;
    logic [7:0]     sel_byte;

    assign reading = (mode == MODE_READ);

    always_ff @(posedge clk) begin
        if (rst || !reading) begin
            chunk_ptr <= '0;
            slot_ptr  <= '0;
        end else if (rd_strobe) begin
            if (slot_ptr == SPW'(CODE_BYTES - 1)) begin
                slot_ptr <= '0;
                if (chunk_ptr == CPW'(NUM_CHUNKS - 1)) begin
                    chunk_ptr <= '0;
                end else begin
                    chunk_ptr <= chunk_ptr + 1'b1;
                end
            end else begin
                slot_ptr <= slot_ptr + 1'b1;
            end
        end
    end

    always_comb begin
        int unsigned idx;
        idx      = slot_to_index(32'(slot_ptr));
        sel_byte = '0;
        for (int c = 0; c < NUM_CHUNKS; c++) begin
            for (int b = 0; b < CODE_BYTES; b++) begin
                if (chunk_ptr == CPW'(c) && idx == b) begin
                    sel_byte = codes[c][b*8 +: 8];
                end
            end
        end
    end

    assign ecc_byte = reading ? sel_byte : 8'h00;
endmodule

// File: rtl/nand_hecc_gen.sv
module nand_hecc_gen
    import nhecc_pkg::*;
#(
    parameter int CHUNK_AW   = 8,
    parameter int NUM_CHUNKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       rd_strobe,
    output logic [7:0] ecc_byte
);
    localparam int LINE_W     = 2 * CHUNK_AW;
    localparam int LINE_BYTES = (LINE_W + 7) / 8;
    localparam int CODE_BYTES = LINE_BYTES + 1;
    localparam int CODE_W     = CODE_BYTES * 8;
    localparam int CW         = $clog2(NUM_CHUNKS + 1);

    logic [CHUNK_AW-1:0]               byte_addr;
    logic [CW-1:0]                     chunk_sel;
    logic                              acc_en;
    logic                              clear;
    logic [NUM_CHUNKS-1:0][CODE_W-1:0] codes;

    nhecc_seq #(
        .AW         (CHUNK_AW),
        .NUM_CHUNKS (NUM_CHUNKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .byte_valid (byte_valid),
        .byte_addr  (byte_addr),
        .chunk_sel  (chunk_sel),
        .acc_en     (acc_en),
        .clear      (clear)
    );

    for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
        logic [LINE_W-1:0]       line_par;
        logic [COL_W-1:0]        col_par;
        logic [LINE_BYTES*8-1:0] line_ext;

        nhecc_acc #(
            .AW (CHUNK_AW)
        ) u_acc (
            .clk      (clk),
            .rst      (rst),
            .clear    (clear),
            .en       (acc_en && (chunk_sel == CW'(g))),
            .addr     (byte_addr),
            .data     (byte_data),
            .line_par (line_par),
            .col_par  (col_par)
        );

        assign line_ext = (LINE_BYTES*8)'(line_par);
        // stored form: inverted parities, two spare ones under the column field
        assign codes[g] = {~col_par, 2'b11, ~line_ext};
    end

    nhecc_rd #(
        .NUM_CHUNKS (NUM_CHUNKS),
        .CODE_BYTES (CODE_BYTES)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .rd_strobe (rd_strobe),
        .codes     (codes),
        .ecc_byte  (ecc_byte)
    );
endmodule

// File: rtl/nhecc_chk.sv
module nhecc_chk
    import nhecc_pkg::*;
#(
    parameter int AW         = 8,
    parameter int NUM_CHUNKS = 2,
    parameter int CODE_BYTES = 3,
    localparam int CW        = $clog2(NUM_CHUNKS + 1),
    localparam int CODE_W    = CODE_BYTES * 8,
    localparam int SPW       = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1
) (
    input logic                              clk,
    input logic                              rst,
    input logic [1:0]                        mode,
    input logic                              byte_valid,
    input logic                              rd_strobe,
    input logic [7:0]                        ecc_byte,
    input logic [NUM_CHUNKS-1:0][CODE_W-1:0] codes,
    input logic [AW-1:0]                     byte_addr,
    input logic [CW-1:0]                     chunk_sel
);
    logic [SPW-1:0] slot_seen;
    logic [AW-1:0]  addr_plus;

    assign addr_plus = byte_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_READ) begin
            slot_seen <= '0;
        end else if (rd_strobe) begin
            slot_seen <= (slot_seen == SPW'(CODE_BYTES - 1)) ? '0 : slot_seen + 1'b1;
        end
    end

    AST_SPARE_BITS_SET: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_READ && slot_seen == SPW'(CODE_BYTES - 1)) |-> ecc_byte[1:0] == 2'b11); // R4

    AST_CLEAR_GIVES_FF: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_CLEAR && mode == MODE_READ) |-> ecc_byte == 8'hFF); // R2

    AST_CLEAR_COUNTERS: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == MODE_CLEAR) |-> (byte_addr == '0 && chunk_sel == '0)); // R2

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_IDLE || mode == MODE_READ) |=> $stable(codes)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ACC && byte_valid && chunk_sel < CW'(NUM_CHUNKS)) |=> byte_addr == $past(addr_plus)); // R6

    AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_CLEAR && chunk_sel == CW'(NUM_CHUNKS)) |=> $stable(codes)); // R6
endmodule

bind nand_hecc_gen nhecc_chk #(
    .AW         (CHUNK_AW),
    .NUM_CHUNKS (NUM_CHUNKS),
    .CODE_BYTES (CODE_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .byte_valid (byte_valid),
    .rd_strobe  (rd_strobe),
    .ecc_byte   (ecc_byte),
    .codes      (codes),
    .byte_addr  (byte_addr),
    .chunk_sel  (chunk_sel)
);

// File: tb/nand_hecc_gen_tb.sv
`timescale 1ns/1ps
module nand_hecc_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] ecc_byte;

    always #10 clk = ~clk;

    nand_hecc_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rd_strobe  (rd_strobe),
        .ecc_byte   (ecc_byte)
    );

    int    errs = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [7:0] pg [0:511];
    int         fed = 0;
    logic [7:0] exp_q [$];
    logic [7:0] got [0:15];
    int         n_got = 0;

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code(input int c);
        logic [15:0] lp;
        logic [5:0]  cp;
        logic [7:0]  b;
        logic        p;
        lp = '0;
        cp = '0;
        for (int a = 0; a < 256; a++) begin
            b = pg[c*256 + a];
            p = 1'b0;
            for (int j = 0; j < 8; j++) begin
                p = p ^ b[j];
                if (j % 2 == 0) cp[0] = cp[0] ^ b[j]; else cp[1] = cp[1] ^ b[j];
                if ((j / 2) % 2 == 0) cp[2] = cp[2] ^ b[j]; else cp[3] = cp[3] ^ b[j];
                if (j < 4) cp[4] = cp[4] ^ b[j]; else cp[5] = cp[5] ^ b[j];
            end
            for (int k = 0; k < 8; k++) begin
                if (((a >> k) & 1) == 1) lp[2*k+1] = lp[2*k+1] ^ p;
                else                     lp[2*k]   = lp[2*k] ^ p;
            end
        end
        return {~cp, 2'b11, ~lp};
    endfunction

    function automatic logic [7:0] exp_at(input int k);
        logic [23:0] code;
        int s;
        code = model_code((k % 6) / 3);
        s = k % 3;
        if (s == 0) return code[15:8];
        if (s == 1) return code[7:0];
        return code[23:16];
    endfunction

    task automatic clear_model();
        for (int i = 0; i < 512; i++) pg[i] = 8'h00;
        fed = 0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(posedge clk); #2;
        mode = m;
    endtask

    task automatic arm();
        set_mode(2'b11);
        set_mode(2'b00);
        set_mode(2'b01);
        clear_model();
    endtask

    task automatic feed(input logic [7:0] b, input bit counted);
        @(posedge clk); #2;
        byte_valid = 1'b1;
        byte_data  = b;
        if (counted && fed < 512) begin
            pg[fed] = b;
            fed++;
        end
    endtask

    task automatic feed_end();
        @(posedge clk); #2;
        byte_valid = 1'b0;
    endtask

    // driver: push expectations, then issue the reads
    task automatic read_seq(input int start_k, input int n, input string req);
        cur_req = req;
        n_got = 0;
        for (int i = 0; i < n; i++) exp_q.push_back(exp_at(start_k + i));
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            rd_strobe = 1'b1;
        end
        @(posedge clk); #2;
        rd_strobe = 1'b0;
    endtask

    // monitor: compare each read against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rd_strobe && mode == 2'b10) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, cur_req, ecc_byte, 8'hxx);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(ecc_byte === e, cur_req, ecc_byte, e);
                end
                if (n_got < 16) begin
                    got[n_got] = ecc_byte;
                    n_got++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R10: output is zero outside read-out
        @(negedge clk);
        check(ecc_byte === 8'h00, "R10", ecc_byte, 8'h00);

        // R1: empty code after reset
        set_mode(2'b10);
        read_seq(0, 6, "R1");
        set_mode(2'b00);

        // R3 R4 R5 R6 R7: mixed full page
        arm();
        for (int i = 0; i < 512; i++) feed(8'((i * 37 + 11) ^ (i >> 4)), 1'b1);
        feed_end();
        set_mode(2'b00);
        @(negedge clk);
        check(ecc_byte === 8'h00, "R10", ecc_byte, 8'h00);
        set_mode(2'b10);
        read_seq(0, 6, "R3_R4_R5_R7");
        set_mode(2'b00);

        // R6: bytes beyond a full page change nothing
        set_mode(2'b01);
        for (int i = 0; i < 5; i++) feed(8'hA5 + 8'(i), 1'b0);
        feed_end();
        set_mode(2'b00);
        set_mode(2'b10);
        read_seq(0, 6, "R6");
        set_mode(2'b00);

        // R3: single set bit at one address separates line pairs
        arm();
        for (int i = 0; i < 256; i++) feed((i == 90) ? 8'h01 : 8'h00, 1'b1);
        feed_end();
        // R9: strobes while idle are ignored
        set_mode(2'b00);
        for (int i = 0; i < 10; i++) feed(8'h3C, 1'b0);
        feed_end();
        set_mode(2'b10);
        // R9: strobes during read-out are ignored
        byte_valid = 1'b1;
        byte_data  = 8'h81;
        read_seq(0, 6, "R9");
        byte_valid = 1'b0;

        // R8: position returns to start when leaving read-out
        read_seq(0, 2, "R8");
        set_mode(2'b00);
        set_mode(2'b10);
        read_seq(0, 1, "R8");
        // R7: wrap after the sixth byte
        read_seq(1, 6, "R7");
        set_mode(2'b00);

        // all-ones page gives the empty code
        arm();
        for (int i = 0; i < 512; i++) feed(8'hFF, 1'b1);
        feed_end();
        set_mode(2'b00);
        set_mode(2'b10);
        read_seq(0, 6, "R3");
        set_mode(2'b00);

        // R2: clear then read directly
        set_mode(2'b01);
        for (int i = 0; i < 40; i++) feed(8'(i * 13), 1'b0);
        feed_end();
        set_mode(2'b11);
        clear_model();
        set_mode(2'b10);
        read_seq(0, 6, "R2");
        set_mode(2'b00);

        // R11: chunk 1 differs from chunk 0 by one bit
        arm();
        for (int i = 0; i < 256; i++) feed(8'(i * 29 + 3), 1'b1);
        for (int i = 0; i < 256; i++) feed(8'(i * 29 + 3) ^ ((i == 77) ? 8'h20 : 8'h00), 1'b1);
        feed_end();
        set_mode(2'b00);
        set_mode(2'b10);
        read_seq(0, 6, "R11");
        set_mode(2'b00);
        begin
            logic [7:0] d0, d1, d2;
            d0 = got[1] ^ got[4];
            d1 = got[0] ^ got[3];
            d2 = got[2] ^ got[5];
            for (int k = 0; k < 4; k++) begin
                check((d0[2*k] ^ d0[2*k+1]) == 1'b1, "R11", d0, 8'h55);
                check((d1[2*k] ^ d1[2*k+1]) == 1'b1, "R11", d1, 8'h55);
            end
            for (int k = 1; k < 4; k++) begin
                check((d2[2*k] ^ d2[2*k+1]) == 1'b1, "R11", d2, 8'h54);
            end
            check(d2[1:0] == 2'b00, "R11", d2, 8'h54);
        end

        repeat (3) @(posedge clk);
        check(exp_q.size() == 0, "R7", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule